// File: doc/BRIEF.md
# Sweep Rate Divider

This block turns a 10 MHz reference into a stream of single-cycle enable pulses at one of twelve rates for a sweep ramp counter. A 4-bit select input picks the rate. The rates form a 1-2-5 series from 4 MHz down to 800 Hz. With a 4000-step ramp, these give sweep times from 1 ms to 5 s. No clock is derived: every output is an enable in the reference domain.

The fastest rate is 4 MHz, which means dividing 10 MHz by 2.5. A mod-5 prescaler does this. It counts 0,1,2,3,4 and repeats, and its lowest count bit is the 4 MHz enable. That gives two enables in every five reference cycles, spaced alternately three and two cycles apart. This uneven spacing is accepted. Behind the prescaler, a chain of decade counters taps unit, half and fifth rates per level. Each decade advances only on the enable from the level before it.

A change of select does not take effect at once. The block holds it until the next pulse of the rate already running, so a switch never produces an out-of-grid extra pulse. Codes above the highest rate fall back to the slowest rate.

Top module: `sweep_rate_divider`

## Requirements
- R1: While the synchronous reset is asserted, `rate_en` stays low.
- R2: With select 0, `rate_en` pulses twice in every five reference cycles, and successive gaps alternate between 2 and 3 cycles.
- R3: Every `rate_en` pulse is exactly one reference cycle wide.
- R4: For select value s in 0..11, the span of two consecutive output periods is, in reference cycles: 5, 10, 25, 50, 100, 250, 500, 1000, 2500, 5000, 10000, 25000. These are rates of 4 MHz, 2 MHz, 800 kHz, 400 kHz, 200 kHz, 80 kHz, 40 kHz, 20 kHz, 8 kHz, 4 kHz, 2 kHz and 800 Hz.
- R5: Select values 12 to 15 behave exactly as select 11.
- R6: A new select value takes effect only at the next pulse of the rate currently in use. That pulse still falls on the old rate's grid, and pulses at the new rate follow it.
- R7: The select value present during reset is in force right after reset. Counting reference edges from the first edge with reset low, the first pulse comes after edge 1 for select 0 and after edge 23 for select 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | SEL_W (4) | Rate select code, 0 = fastest |
| rate_en | output | 1 | Single-cycle enable pulse at the selected rate |

## Verification
The bench builds the block with its default parameters: four decade levels, a mod-5 prescaler and a 4-bit select. This brings the full twelve-rate set into one run, including the 800 Hz tail with its 12,500-cycle period and the four unused select codes that must clamp to it. Two of these rates have uneven spacing, the 4 MHz and 800 kHz outputs. For those, the bench checks the sum of two periods rather than single gaps. The deferred-select behaviour is checked by switching from the slowest rate to the fastest one just after a pulse and timing the full old-rate period that must pass first.

// File: rtl/sweep_div_pkg.sv
package sweep_div_pkg;
   // positions of the three rate taps every decade level provides
   localparam int TAP_UNIT  = 0;
   localparam int TAP_HALF  = 1;
   localparam int TAP_FIFTH = 2;
   localparam int TAPS_PER_LEVEL = 3;

   function automatic int rate_total(input int levels);
      return TAPS_PER_LEVEL * levels;
   endfunction
endpackage

// File: rtl/sweep_frac_prescaler.sv
// Fractional prescaler: an odd-modulus counter whose lowest bit is the enable.
// With MOD=5 this yields two enables per five cycles (divide by 2.5).
module sweep_frac_prescaler #(
   parameter int MOD = 5
) (
   input  logic clk,
   input  logic rst,
   output logic pulse_o
);
   localparam int CW = $clog2(MOD);

   if (MOD < 3 || (MOD % 2) == 0) begin : g_bad_mod
      $error("prescaler modulus must be odd and at least 3");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (cnt_q == CW'(MOD - 1))
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CW'(1);
   end

   // odd modulus => the wrap state is even, so two high states never touch
   assign pulse_o = cnt_q[0];
endmodule

// File: rtl/sweep_decade.sv
// One decade level: counts incoming enables and taps unit, half and fifth rates.
module sweep_decade #(
   parameter int RADIX = 10,
   parameter int DIV_A = 2,
   parameter int DIV_B = 5
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       step_i,
   output logic [2:0] taps_o,
   output logic       carry_o
);
   import sweep_div_pkg::*;
   localparam int CW = $clog2(RADIX);

   if ((RADIX % DIV_A) != 0 || (RADIX % DIV_B) != 0) begin : g_bad_div
      $error("decade tap divisors must divide the radix");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (step_i) begin
         if (cnt_q == CW'(RADIX - 1))
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + CW'(1);
      end
   end

   assign taps_o[TAP_UNIT]  = step_i;
   assign taps_o[TAP_HALF]  = step_i && ((cnt_q % CW'(DIV_A)) == CW'(DIV_A - 1));
   assign taps_o[TAP_FIFTH] = step_i && ((cnt_q % CW'(DIV_B)) == CW'(DIV_B - 1));
   assign carry_o           = step_i && (cnt_q == CW'(RADIX - 1));
endmodule

// File: rtl/sweep_rate_select.sv
// Holds the active select code; a new code is adopted only on an output pulse.
module sweep_rate_select #(
   parameter int NUM_RATES = 12,
   parameter int SEL_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [SEL_W-1:0]     sel_i,
   input  logic [NUM_RATES-1:0] taps_i,
   output logic [SEL_W-1:0]     act_sel_o,
   output logic                 pulse_o
);
   localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(NUM_RATES - 1);

   logic [SEL_W-1:0] req_sel;
   logic [SEL_W-1:0] act_q;

   assign req_sel = (sel_i > TOP_SEL) ? TOP_SEL : sel_i;

   always_ff @(posedge clk) begin
      if (rst)
         act_q <= req_sel;
      else if (pulse_o)
         act_q <= req_sel;
   end

   assign pulse_o   = taps_i[act_q];
   assign act_sel_o = act_q;
endmodule

// File: rtl/sweep_rate_divider.sv
module sweep_rate_divider #(
   parameter int LEVELS  = 4,
   parameter int SEL_W   = 4,
   parameter int PRE_MOD = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] rate_sel,
   output logic             rate_en
);
   import sweep_div_pkg::*;
   localparam int NUM_RATES = rate_total(LEVELS);

   if (LEVELS < 1) begin : g_bad_levels
      $error("at least one decade level is required");
   end
   if (NUM_RATES > (1 << SEL_W)) begin : g_bad_sel
      $error("select width too narrow for the rate count");
   end

   logic                 base_en;
   logic [LEVELS:0]      step;
   logic [NUM_RATES-1:0] taps;
   logic [SEL_W-1:0]     act_sel;
   logic                 unused_tail_carry;

   sweep_frac_prescaler #(.MOD(PRE_MOD)) u_pre (
      .clk     (clk),
      .rst     (rst),
      .pulse_o (base_en)
   );

   assign step[0] = base_en;

   for (genvar l = 0; l < LEVELS; l++) begin : g_level
      sweep_decade u_dec (
         .clk     (clk),
         .rst     (rst),
         .step_i  (step[l]),
         .taps_o  (taps[TAPS_PER_LEVEL*l +: TAPS_PER_LEVEL]),
         .carry_o (step[l+1])
      );
   end

   assign unused_tail_carry = step[LEVELS];

   sweep_rate_select #(.NUM_RATES(NUM_RATES), .SEL_W(SEL_W)) u_sel (
      .clk       (clk),
      .rst       (rst),
      .sel_i     (rate_sel),
      .taps_i    (taps),
      .act_sel_o (act_sel),
      .pulse_o   (rate_en)
   );
endmodule

// File: rtl/sweep_div_chk.sv
module sweep_div_chk #(
   parameter int NUM_RATES = 12,
   parameter int SEL_W     = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             base_en,
   input logic [SEL_W-1:0] act_sel,
   input logic             rate_en
);
   // R2: prescaler never idles for three cycles in a row
   assert_two_in_five_R2: assert property (@(posedge clk) disable iff (rst)
      (!base_en && $past(!base_en)) |=> base_en);

   // R3: output pulses are one cycle wide
   assert_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
      rate_en |=> !rate_en);

   // R4: every output pulse lies on the 4 MHz grid
   assert_on_base_grid_R4: assert property (@(posedge clk) disable iff (rst)
      rate_en |-> base_en);

   // R5: active code never exceeds the slowest rate
   assert_sel_clamped_R5: assert property (@(posedge clk) disable iff (rst)
      act_sel <= SEL_W'(NUM_RATES - 1));

   // R6: active code only moves on an output pulse
   assert_switch_on_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      !rate_en |=> $stable(act_sel));
endmodule

bind sweep_rate_divider sweep_div_chk #(.NUM_RATES(NUM_RATES), .SEL_W(SEL_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .base_en (base_en),
   .act_sel (act_sel),
   .rate_en (rate_en)
);

// File: tb/sim_sweep_rate_divider.sv
`timescale 1ns/1ps
module sim_sweep_rate_divider;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] sel = 4'd0;
   logic       rate_en;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int wide_pulses = 0;
   logic prev_en = 1'b0;
   logic finished = 1'b0;

   // stimulus select code and expected two-period span (R4)
   localparam int NV = 12;
   localparam int VEC_SEL [NV]  = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11};
   localparam int VEC_SPAN [NV] = '{5, 10, 25, 50, 100, 250, 500, 1000,
                                    2500, 5000, 10000, 25000};

   always #2 clk = ~clk;

   sweep_rate_divider u0 (
      .clk      (clk),
      .rst      (rst),
      .rate_sel (sel),
      .rate_en  (rate_en)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // R3 monitor: no two consecutive high samples
   always @(negedge clk) begin
      if (!rst && prev_en && rate_en) wide_pulses <= wide_pulses + 1;
      prev_en <= rate_en;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_pulse(output int at);
      do @(negedge clk); while (!rate_en);
      at = cyc;
   endtask

   task automatic reset_run(input logic [3:0] s, input int exp_first);
      int n;
      rst = 1'b1;
      sel = s;
      repeat (4) @(negedge clk);
      check(rate_en == 1'b0, "R1 quiet in reset", int'(rate_en), 0);
      rst = 1'b0;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!rate_en && n < 200);
      check(n == exp_first, "R7 first pulse after reset", n, exp_first);
   endtask

   initial begin
      int t0, t1, t2, tx;
      reset_run(4'd0, 1);
      reset_run(4'd3, 23);
      reset_run(4'd1, 3);

      // table walk (R4, R2 on code 0)
      for (int i = 0; i < NV; i++) begin
         sel = 4'(VEC_SEL[i]);
         wait_pulse(tx);
         wait_pulse(t0);
         wait_pulse(t1);
         wait_pulse(t2);
         check(t2 - t0 == VEC_SPAN[i], $sformatf("R4 span sel=%0d", VEC_SEL[i]),
               t2 - t0, VEC_SPAN[i]);
         if (VEC_SEL[i] == 0)
            check(((t1 - t0) == 2 && (t2 - t1) == 3) || ((t1 - t0) == 3 && (t2 - t1) == 2),
                  "R2 gap pattern", (t1 - t0) * 10 + (t2 - t1), 23);
      end

      // R5: unused code behaves as slowest rate
      sel = 4'd15;
      wait_pulse(t0);
      wait_pulse(t1);
      wait_pulse(t2);
      check(t2 - t0 == 25000, "R5 code 15 span", t2 - t0, 25000);

      // R6: switch to fastest right after a slow pulse
      @(negedge clk);
      sel = 4'd0;
      wait_pulse(t0);
      check(t0 - t2 == 12500, "R6 old period completes", t0 - t2, 12500);
      wait_pulse(t1);
      check((t1 - t0) == 2 || (t1 - t0) == 3, "R6 new rate follows", t1 - t0, 3);

      check(wide_pulses == 0, "R3 pulse width", wide_pulses, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule